// File: doc/BRIEF.md
# Multi-Port Serial PCM Receiver

This block receives stereo PCM audio on one of three serial input ports. Each port carries a word clock, a bit clock and a data line. A fixed-priority selector picks the lowest-numbered enabled port. The block runs entirely on a fast system clock: it brings the chosen port's lines in through two-flop synchronisers and detects rising bit-clock edges. On each detected edge it takes one data bit and one word-clock level.

The framing decoder handles three justification styles:
- I2S, with its one-bit delay after the word-clock edge.
- 16-bit right-justified.
- 24-bit left-justified.

Frames can be 32, 48 or 64 bit clocks long. Every captured word is left-aligned into a 24-bit sample. A one-cycle strobe marks each completed left/right pair.

Changing the format, the slot length or the winning port flushes the frame state, so a half-assembled frame never reaches the outputs. The master clock that accompanies each port is not taken in, because all timing comes from oversampling.

Top module: `pcm_port_rx`

## Requirements
- R1: After reset, `sample_valid` is 0, both sample outputs are 0 and `active_port` reads 3.
- R2: `active_port` names the lowest-numbered enabled port (0 beats 1, 1 beats 2), and only that port's lines affect the samples; traffic on any other port, enabled or not, has no effect.
- R3: `fmt_sel` = 0 (I2S): word clock low marks the left channel, the MSB arrives on the second bit clock after the word-clock edge, and the first min(24, H) bits of the half-frame are left-aligned into 24 bits with zero fill below.
- R4: `fmt_sel` = 1 (right-justified 16-bit): word clock high marks the left channel, the last 16 bits of each half-frame land in sample bits 23:8, and bits 7:0 are 0.
- R5: `fmt_sel` = 2, and the alias 3 (left-justified 24-bit): word clock high marks the left channel, the MSB is on the first bit clock of the half-frame, and the first min(24, H) bits are left-aligned with zero fill.
- R6: `slot_sel` 0/1/2/3 selects 32/48/64/64 bit clocks per frame, giving H = 16/24/32 bits per half-frame. A half-frame of any other length is discarded, and a frame with a discarded half produces no strobe.
- R7: `sample_valid` is a one-cycle pulse raised once per frame, after its right half completes. It carries that frame's left and right words. A right half without a preceding good left half is not emitted.
- R8: A change of `fmt_sel`, `slot_sel` or the winning port clears the frame state. The frame in progress at that moment is not emitted.
- R9: With no port enabled, `active_port` reads 3 and no strobe is raised.
- R10: `left_out` and `right_out` change only in a cycle where `sample_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than any bit clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | NPORTS | Per-port enable; lowest enabled index wins |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 right-justified 16, 2/3 left-justified 24 |
| slot_sel | input | 2 | Frame length: 0 = 32, 1 = 48, 2/3 = 64 bit clocks |
| wclk_in | input | NPORTS | Word clock of each port |
| bclk_in | input | NPORTS | Bit clock of each port |
| sdata_in | input | NPORTS | Serial data of each port |
| left_out | output | SAMPLE_W | Left sample, left-aligned |
| right_out | output | SAMPLE_W | Right sample, left-aligned |
| sample_valid | output | 1 | One-cycle strobe for a new stereo pair |
| active_port | output | SEL_W | Winning port index, NPORTS when none |

## Verification
The assertions take for granted that each bit-clock level lasts at least two system clocks. This guarantees that detected rising edges are at least two cycles apart. They also take for granted that word clock and data move only while the bit clock is low, so all three lines cross the synchronisers together.

The stimulus holds every bit-clock phase for four system clocks and changes word clock and data only at the start of the low phase. Configuration changes are made only in gaps between serial frames, apart from the one deliberate mid-frame change.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;
  localparam int MAX_HALF = 32;

  typedef enum logic [1:0] {
    FMT_I2S      = 2'd0,
    FMT_RJ16     = 2'd1,
    FMT_LJ24     = 2'd2,
    FMT_LJ24_ALT = 2'd3
  } pcm_fmt_e;

  // bit clocks in one half-frame for a slot-length code
  function automatic logic [5:0] half_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/pcmrx_sync.sv
module pcmrx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pcmrx_prio.sv
module pcmrx_prio #(
  parameter int N     = 3,
  parameter int SEL_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     en,
  output logic [SEL_W-1:0] idx_q
);
  localparam logic [SEL_W-1:0] NONE_IDX = SEL_W'(N);

  logic [SEL_W-1:0] win;

  always_comb begin
    win = NONE_IDX;
    for (int i = N - 1; i >= 0; i--) begin
      if (en[i]) win = SEL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= NONE_IDX;
    else     idx_q <= win;
  end

  // R2: port 0 enabled always takes the grant
  a_r2_port0_wins: assert property (@(posedge clk) disable iff (rst)
    en[0] |=> (idx_q == '0));
  // R2: port 1 enabled without port 0 takes the grant
  a_r2_port1_next: assert property (@(posedge clk) disable iff (rst)
    (en[1:0] == 2'b10) |=> (idx_q == SEL_W'(1)));
  // R9: nothing enabled, no grant
  a_r9_no_grant: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> (idx_q == NONE_IDX));
endmodule

// File: rtl/pcmrx_deframer.sv
module pcmrx_deframer
  import pcmrx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RJ_W     = 16,
  parameter int SHIFT_W  = MAX_HALF,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  pcm_fmt_e            fmt,
  input  logic [1:0]          slot,
  input  logic                bclk,
  input  logic                wclk,
  input  logic                sdat,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q,
  output logic                valid_q
);
  localparam int PAD_W = SAMPLE_W - RJ_W;

  logic                bclk_d;
  logic                ws_d1;
  logic                ws_prev;
  logic                primed;
  logic                armed;
  logic                have_left;
  logic [CNT_W-1:0]    cnt;
  logic [SHIFT_W-1:0]  shreg;
  logic [SAMPLE_W-1:0] left_hold;

  logic                rise;
  logic                ws_eff;
  logic                boundary;
  logic [CNT_W-1:0]    hlen;
  logic [CNT_W-1:0]    sh_amt;
  logic                len_ok;
  logic                prev_left;
  logic [SHIFT_W-1:0]  aligned;
  logic [SAMPLE_W-1:0] word;

  always_comb begin
    rise      = bclk & ~bclk_d;
    // I2S is left-justified framing against a word clock delayed by one bit
    ws_eff    = (fmt == FMT_I2S) ? ws_d1 : wclk;
    boundary  = primed && (ws_eff != ws_prev);
    hlen      = CNT_W'(half_bits(slot));
    len_ok    = (cnt == hlen);
    prev_left = (fmt == FMT_I2S) ? ~ws_prev : ws_prev;
    sh_amt    = CNT_W'(SHIFT_W) - hlen;
    aligned   = shreg << sh_amt;
    if (fmt == FMT_RJ16) word = {shreg[RJ_W-1:0], {PAD_W{1'b0}}};
    else                 word = aligned[SHIFT_W-1 -: SAMPLE_W];
  end

  always_ff @(posedge clk) begin
    valid_q <= 1'b0;
    if (rst) begin
      bclk_d    <= 1'b0;
      ws_d1     <= 1'b0;
      ws_prev   <= 1'b0;
      primed    <= 1'b0;
      armed     <= 1'b0;
      have_left <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      left_hold <= '0;
      left_q    <= '0;
      right_q   <= '0;
    end else if (clr) begin
      bclk_d    <= bclk;
      primed    <= 1'b0;
      armed     <= 1'b0;
      have_left <= 1'b0;
      cnt       <= '0;
    end else begin
      bclk_d <= bclk;
      if (rise) begin
        ws_d1 <= wclk;
        shreg <= {shreg[SHIFT_W-2:0], sdat};
        if (!primed) begin
          primed  <= 1'b1;
          ws_prev <= wclk;
          cnt     <= CNT_W'(1);
        end else begin
          ws_prev <= ws_eff;
          if (boundary) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b1;
            if (armed && len_ok) begin
              if (prev_left) begin
                left_hold <= word;
                have_left <= 1'b1;
              end else if (have_left) begin
                left_q    <= left_hold;
                right_q   <= word;
                valid_q   <= 1'b1;
                have_left <= 1'b0;
              end
            end else if (armed) begin
              have_left <= 1'b0;
            end
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R7: strobe lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  // R8: a flush never lets a strobe through
  a_r8_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid_q);
  // R10: samples only move together with the strobe
  a_r10_left_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(left_q) |-> valid_q);
  a_r10_right_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(right_q) |-> valid_q);
endmodule

// File: rtl/pcm_port_rx.sv
module pcm_port_rx
  import pcmrx_pkg::*;
#(
  parameter int NPORTS   = 3,
  parameter int SAMPLE_W = 24,
  parameter int RJ_W     = 16,
  parameter int SEL_W    = $clog2(NPORTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORTS-1:0]   port_en,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          slot_sel,
  input  logic [NPORTS-1:0]   wclk_in,
  input  logic [NPORTS-1:0]   bclk_in,
  input  logic [NPORTS-1:0]   sdata_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                sample_valid,
  output logic [SEL_W-1:0]    active_port
);
  localparam logic [SEL_W-1:0] NONE_IDX = SEL_W'(NPORTS);
  localparam int LINES = 3;

  logic [LINES-1:0] port_s [NPORTS];
  logic [SEL_W-1:0] idx_q;
  logic [SEL_W-1:0] idx_qq;
  logic [3:0]       cfg_q;
  logic [3:0]       cfg_qq;
  logic             clr;
  logic             bclk_m;
  logic             wclk_m;
  logic             sdat_m;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port_sync
    pcmrx_sync #(.W(LINES)) i_sync (
      .clk (clk),
      .rst (rst),
      .d   ({bclk_in[p], wclk_in[p], sdata_in[p]}),
      .q   (port_s[p])
    );
  end

  pcmrx_prio #(.N(NPORTS), .SEL_W(SEL_W)) i_prio (
    .clk   (clk),
    .rst   (rst),
    .en    (port_en),
    .idx_q (idx_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      cfg_qq <= '0;
      idx_qq <= NONE_IDX;
    end else begin
      cfg_q  <= {fmt_sel, slot_sel};
      cfg_qq <= cfg_q;
      idx_qq <= idx_q;
    end
  end

  always_comb begin
    clr = (cfg_q != cfg_qq) || (idx_q != idx_qq) || (idx_q == NONE_IDX);
    {bclk_m, wclk_m, sdat_m} = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (idx_q == SEL_W'(i)) {bclk_m, wclk_m, sdat_m} = port_s[i];
    end
  end

  pcmrx_deframer #(.SAMPLE_W(SAMPLE_W), .RJ_W(RJ_W)) i_deframer (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .fmt     (pcm_fmt_e'(cfg_q[3:2])),
    .slot    (cfg_q[1:0]),
    .bclk    (bclk_m),
    .wclk    (wclk_m),
    .sdat    (sdat_m),
    .left_q  (left_out),
    .right_q (right_out),
    .valid_q (sample_valid)
  );

  assign active_port = idx_q;

  // R1: reset leaves the outputs idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!sample_valid && active_port == NONE_IDX));
  // R9: no strobe while no port holds the grant
  a_r9_silent: assert property (@(posedge clk) disable iff (rst)
    (active_port == NONE_IDX) |=> !sample_valid);
endmodule

// File: tb/test_pcm_port_rx.sv
module test_pcm_port_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  port_en = '0;
  logic [1:0]  fmt_sel = '0;
  logic [1:0]  slot_sel = '0;
  logic [2:0]  wclk_b = '0;
  logic [2:0]  bclk_b = '0;
  logic [2:0]  sd_b = '0;
  logic [23:0] left_out, right_out;
  logic        sample_valid;
  logic [1:0]  active_port;

  int          n_chk = 0, n_bad = 0, n_valid = 0;
  logic [23:0] q_l[$], q_r[$];
  logic [23:0] exl, exr, last_l = '0, last_r = '0;
  string       cur_req = "R1";
  int          tx_port = 0;
  logic [2:0]  junk = '0;
  logic [1:0]  tx_fmt = '0;
  logic        pend = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pcm_port_rx i_pcm_port_rx (
    .clk          (clk),
    .rst          (rst),
    .port_en      (port_en),
    .fmt_sel      (fmt_sel),
    .slot_sel     (slot_sel),
    .wclk_in      (wclk_b),
    .bclk_in      (bclk_b),
    .sdata_in     (sd_b),
    .left_out     (left_out),
    .right_out    (right_out),
    .sample_valid (sample_valid),
    .active_port  (active_port)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && sample_valid) begin
      n_valid++;
      last_l = left_out;
      last_r = right_out;
      if (q_l.size() == 0) begin
        check(1'b0, cur_req, "unexpected pair", {left_out, right_out}, 48'h0);
      end else begin
        exl = q_l.pop_front();
        exr = q_r.pop_front();
        check({left_out, right_out} === {exl, exr}, cur_req, "sample pair",
              {left_out, right_out}, {exl, exr});
      end
    end
  end

  function automatic int hbits(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction

  function automatic logic tx_bit(input logic [1:0] f, input int h,
                                  input logic [23:0] s, input int i);
    if (f == 2'd1) begin
      if (i >= h - 16) return s[23 - (i - (h - 16))];
      return logic'(i % 2);
    end
    if (i < 24) return s[23 - i];
    return 1'b0;
  endfunction

  function automatic logic [23:0] expect_word(input logic [1:0] f, input int h,
                                              input logic [23:0] s);
    if (f == 2'd1 || h == 16) return {s[23:8], 8'h00};
    return s;
  endfunction

  task automatic send_bit(input logic ws, input logic d);
    logic dl;
    dl   = (tx_fmt == 2'd0) ? pend : d;
    pend = d;
    for (int p = 0; p < 3; p++) begin
      bclk_b[p] = 1'b0;
      if (p == tx_port)  begin wclk_b[p] = ws;   sd_b[p] = dl;  end
      else if (junk[p])  begin wclk_b[p] = ~ws;  sd_b[p] = ~dl; end
      else               begin wclk_b[p] = 1'b0; sd_b[p] = 1'b0; end
    end
    repeat (BH) @(negedge clk);
    for (int p = 0; p < 3; p++) if (p == tx_port || junk[p]) bclk_b[p] = 1'b1;
    repeat (BH) @(negedge clk);
  endtask

  task automatic send_half(input logic lvl, input logic [23:0] s, input int h);
    for (int i = 0; i < h; i++) send_bit(lvl, tx_bit(tx_fmt, h, s, i));
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                            input int h, input bit push);
    logic lvl;
    lvl = (tx_fmt == 2'd0) ? 1'b0 : 1'b1;
    if (push) begin
      q_l.push_back(expect_word(tx_fmt, h, l));
      q_r.push_back(expect_word(tx_fmt, h, r));
    end
    send_half(lvl, l, h);
    send_half(~lvl, r, h);
  endtask

  task automatic setup(input logic [1:0] f, input logic [1:0] s, input int port,
                       input logic [2:0] en, input logic [2:0] jm, input string req);
    cur_req  = req;
    fmt_sel  = f;
    slot_sel = s;
    port_en  = en;
    tx_fmt   = f;
    tx_port  = port;
    junk     = jm;
    repeat (6) @(negedge clk);
    repeat (3) send_bit((f == 2'd0) ? 1'b1 : 1'b0, 1'b0);
  endtask

  task automatic run_case(input logic [1:0] f, input logic [1:0] s, input int port,
                          input logic [2:0] en, input logic [2:0] jm, input int nfr,
                          input int seed, input int h, input bit push, input string req);
    int v0;
    logic [23:0] l, r;
    setup(f, s, port, en, jm, req);
    v0 = n_valid;
    for (int k = 0; k < nfr; k++) begin
      l = 24'(32'(seed) * 32'h009E3779 + 32'(k) * 32'h0051ED27);
      r = 24'(32'(seed) * 32'h00C2B2AE + 32'(k) * 32'h00165667) ^ 24'h5A5A5A;
      if (k == 1) begin l = 24'h7FFFFF; r = 24'h800000; end
      send_frame(l, r, h, push);
    end
    send_half((f == 2'd0) ? 1'b0 : 1'b1, 24'h0, h);
    repeat (8) @(negedge clk);
    check(q_l.size() == 0, req, "pending frames left", 48'(q_l.size()), 48'h0);
    if (!push) begin
      check(n_valid == v0, req, "strobes while ignored", 48'(n_valid - v0), 48'h0);
      check({left_out, right_out} === {last_l, last_r}, "R10", "held samples",
            {left_out, right_out}, {last_l, last_r});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(sample_valid === 1'b0, "R1", "valid", 48'(sample_valid), 48'h0);
    check({left_out, right_out} === 48'h0, "R1", "samples", {left_out, right_out}, 48'h0);
    check(active_port === 2'd3, "R1", "active port", 48'(active_port), 48'd3);

    // R3 R4 R5 R6: every format at every slot length on port 0
    for (int f = 0; f < 3; f++) begin
      for (int s = 0; s < 3; s++) begin
        run_case(2'(f), 2'(s), 0, 3'b001, 3'b000, 3, f * 3 + s + 1, hbits(2'(s)), 1'b1,
                 (f == 0) ? "R3" : (f == 1) ? "R4" : "R5");
      end
    end
    // R5 R6: alias codes
    run_case(2'd3, 2'd3, 0, 3'b001, 3'b000, 2, 40, 32, 1'b1, "R5");
    run_case(2'd2, 2'd3, 0, 3'b001, 3'b000, 2, 41, 32, 1'b1, "R6");

    // R2: priority with traffic on losing ports
    run_case(2'd2, 2'd1, 0, 3'b011, 3'b110, 2, 50, 24, 1'b1, "R2");
    check(active_port === 2'd0, "R2", "port 0 over 1", 48'(active_port), 48'd0);
    run_case(2'd0, 2'd2, 1, 3'b110, 3'b101, 2, 51, 32, 1'b1, "R2");
    check(active_port === 2'd1, "R2", "port 1 over 2", 48'(active_port), 48'd1);
    run_case(2'd1, 2'd0, 2, 3'b100, 3'b011, 2, 52, 16, 1'b1, "R2");
    check(active_port === 2'd2, "R2", "port 2 alone", 48'(active_port), 48'd2);
    // R2: data only on the losing port is ignored
    run_case(2'd2, 2'd0, 1, 3'b011, 3'b000, 2, 53, 16, 1'b0, "R2");
    check(active_port === 2'd0, "R2", "grant kept", 48'(active_port), 48'd0);

    // R9: nothing enabled
    run_case(2'd2, 2'd0, 0, 3'b000, 3'b000, 2, 54, 16, 1'b0, "R9");
    check(active_port === 2'd3, "R9", "no grant", 48'(active_port), 48'd3);

    // R6: half-frame length disagrees with the slot setting
    run_case(2'd2, 2'd2, 0, 3'b001, 3'b000, 2, 55, 24, 1'b0, "R6");
    run_case(2'd1, 2'd0, 0, 3'b001, 3'b000, 2, 56, 24, 1'b0, "R6");

    // R8 R7: format change mid-frame drops that frame
    setup(2'd2, 2'd0, 0, 3'b001, 3'b000, "R8");
    v0 = n_valid;
    send_frame(24'h123456, 24'h654321, 16, 1'b1);
    send_half(1'b1, 24'hABCDEF, 16);
    fmt_sel = 2'd1;
    send_half(1'b0, 24'h13579B, 16);
    send_half(1'b1, 24'h0, 16);
    repeat (8) @(negedge clk);
    check(q_l.size() == 0, "R8", "frame before change", 48'(q_l.size()), 48'h0);
    check(n_valid - v0 == 1, "R7", "one strobe only", 48'(n_valid - v0), 48'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule